// File: doc/BRIEF.md
# Secure Memory Integrity Unit

This unit sits between a core whose registers carry compartment ownership tags and a memory that is not trusted. It handles one secure word store or one secure word load at a time. A store is allowed only when the ownership tag of the source register matches the compartment that is running. The unit then encrypts the word with that compartment's session key and computes a keyed integrity code over the key, the virtual address and the plaintext. The ciphertext and the code go to memory together in a single write beat.

A load reads the ciphertext and the stored code, decrypts the word and recomputes the code. If the two codes agree, the unit returns the plaintext tagged with the running compartment's ID. If they disagree, it reports an integrity fault. Because the address is part of the code, a valid word that is copied to another address is rejected. Because the key is part of the code, a word stored by another compartment is rejected as well.

The unit looks up the session key through a key-table port. The cipher is a keyed XOR placeholder. The integrity code is a CRC with a fixed polynomial, processed in chunks of a parameter width, one chunk per cycle.

Top module: `secmem_guard`

## Requirements
- R1: After reset, req_ready is 1 and busy, rsp_valid and mem_req_valid are 0. A request is taken on a clock edge where req_valid and req_ready are both 1. From that edge until the edge that ends its response cycle, busy is 1 and req_ready is 0.
- R2: A store whose req_src_tag differs from cur_id gives a response with rsp_viol=1 in the cycle right after the accepting edge, and issues no memory request.
- R3: key_id always equals cur_id, and key_in is sampled on the accepting edge. The keystream is the XOR of all DATA_W-bit slices of the key, with bit 0 of the key in bit 0 of the first slice. The ciphertext is the plaintext XOR the keystream.
- R4: The integrity code is a CRC of width MAC_W with polynomial POLY, initial value zero and no reflection. It is computed most significant bit first over the bit string {key, address, plaintext}, which is MSG_W bits long. For each message bit b: the feedback is crc[MSB] XOR b, the CRC shifts left by one, and POLY is XORed in when the feedback is 1.
- R5: An accepted store with a matching tag produces exactly one memory write beat. That beat carries mem_req_addr, the ciphertext and the code together. While mem_req_valid is 1 and mem_req_ready is 0, the request fields stay stable.
- R6: A load whose recomputed code equals the stored code returns the plaintext on rsp_data, with rsp_tag_valid=1, rsp_tag equal to the cur_id sampled at acceptance, and rsp_mac_err=0.
- R7: A load whose stored ciphertext or code has been altered returns rsp_mac_err=1, rsp_data=0, rsp_tag=0 and rsp_tag_valid=0.
- R8: A valid ciphertext and code pair copied to a different address fails the load check there, as in R7.
- R9: A load issued under a compartment ID other than the one that stored the word fails the check, as in R7.
- R10: Only one request is in flight at a time. Each accepted request produces exactly one response, and rsp_valid stays high for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_store | input | 1 | 1 = secure store, 0 = secure load |
| req_addr | input | ADDR_W | Virtual address of the word |
| req_wdata | input | DATA_W | Plaintext to store |
| req_src_tag | input | ID_W | Ownership tag of the source register |
| cur_id | input | ID_W | ID of the running compartment |
| key_id | output | ID_W | Key-table index (the running compartment) |
| key_in | input | KEY_W | Session key returned by the key table |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | DATA_W | Plaintext from a load, 0 otherwise |
| rsp_tag | output | ID_W | Destination ownership tag for a good load |
| rsp_tag_valid | output | 1 | rsp_tag is meaningful |
| rsp_viol | output | 1 | Ownership violation on a store |
| rsp_mac_err | output | 1 | Integrity check failed on a load |
| busy | output | 1 | A request is in progress |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write beat, 0 = read |
| mem_req_addr | output | ADDR_W | Memory address |
| mem_req_wdata | output | DATA_W | Ciphertext to write |
| mem_req_wmac | output | MAC_W | Integrity code to write |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_rdata | input | DATA_W | Ciphertext read back |
| mem_rsp_rmac | input | MAC_W | Integrity code read back |

## Verification
Some properties are checked on every cycle. After an ownership violation the response follows on the next cycle with no memory request. A stalled memory request holds all of its fields. A response lasts exactly one cycle. A failed integrity check never carries data or a valid tag. The CRC engine is never restarted while it is running. The bench scenarios show everything that depends on data. They confirm that the ciphertext and code match independently computed values, that a round trip returns the stored word with the right tag, and that bit flips in the data or the code, a word spliced to another address, and a load by the wrong compartment each raise the fault. Random memory stalls and read latencies exercise the handshakes.

// File: rtl/secmem_pkg.sv
package secmem_pkg;

   typedef enum logic [2:0] {
      SM_IDLE    = 3'd0,
      SM_HASH    = 3'd1,
      SM_MEMREQ  = 3'd2,
      SM_MEMWAIT = 3'd3,
      SM_RESP    = 3'd4
   } secmem_state_e;

endpackage

// File: rtl/secmem_xor_cipher.sv
// Keyed XOR placeholder cipher: the keystream folds every DATA_W slice of the key.
module secmem_xor_cipher #(
   parameter int DATA_W = 32,
   parameter int KEY_W  = 128
) (
   input  logic [DATA_W-1:0] din,
   input  logic [KEY_W-1:0]  key,
   output logic [DATA_W-1:0] dout
);

   localparam int NSL = (KEY_W + DATA_W - 1) / DATA_W;
   localparam int PW  = NSL * DATA_W;

   logic [DATA_W-1:0] kstream;

   generate
      if (DATA_W < 1 || KEY_W < 1) begin : g_bad
         $error("secmem_xor_cipher: widths must be positive");
      end
      if (KEY_W == DATA_W) begin : g_direct
         assign kstream = key;
      end else begin : g_fold
         logic [PW-1:0] kpad;
         assign kpad = PW'(key);
         always_comb begin
            kstream = '0;
            for (int s = 0; s < NSL; s++) begin
               kstream = kstream ^ kpad[s*DATA_W +: DATA_W];
            end
         end
      end
   endgenerate

   assign dout = din ^ kstream;

endmodule

// File: rtl/secmem_crc_seq.sv
// Chunked CRC engine: CHUNK_W message bits per cycle, MSB first, zero initial value.
module secmem_crc_seq #(
   parameter int               MAC_W   = 128,
   parameter int               MSG_W   = 192,
   parameter int               CHUNK_W = 16,
   parameter logic [MAC_W-1:0] POLY    = 128'h87
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [MSG_W-1:0] msg,
   output logic             done,
   output logic [MAC_W-1:0] code
);

   localparam int NCH   = MSG_W / CHUNK_W;
   localparam int CNT_W = (NCH > 1) ? $clog2(NCH) : 1;

   generate
      if (MSG_W % CHUNK_W != 0) begin : g_bad_chunk
         $error("secmem_crc_seq: CHUNK_W must divide MSG_W");
      end
      if (MAC_W < 2) begin : g_bad_mac
         $error("secmem_crc_seq: MAC_W too small");
      end
   endgenerate

   function automatic logic [MAC_W-1:0] crc_chunk(input logic [MAC_W-1:0] c_in,
                                                  input logic [CHUNK_W-1:0] bits);
      logic [MAC_W-1:0] c;
      logic             fb;
      c = c_in;
      for (int i = CHUNK_W - 1; i >= 0; i--) begin
         fb = c[MAC_W-1] ^ bits[i];
         c  = {c[MAC_W-2:0], 1'b0};
         if (fb) c = c ^ POLY;
      end
      return c;
   endfunction

   generate
      if (NCH == 1) begin : g_single
         logic             done_q;
         logic [MAC_W-1:0] crc_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               done_q <= 1'b0;
               crc_q  <= '0;
            end else begin
               done_q <= start;
               if (start) crc_q <= crc_chunk('0, msg);
            end
         end
         assign done = done_q;
         assign code = crc_q;
      end else begin : g_iter
         logic [MSG_W-1:0] sh_q;
         logic [MAC_W-1:0] crc_q;
         logic [CNT_W-1:0] cnt_q;
         logic             run_q;
         logic             done_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh_q   <= '0;
               crc_q  <= '0;
               cnt_q  <= '0;
               run_q  <= 1'b0;
               done_q <= 1'b0;
            end else if (start) begin
               sh_q   <= msg;
               crc_q  <= '0;
               cnt_q  <= '0;
               run_q  <= 1'b1;
               done_q <= 1'b0;
            end else if (run_q) begin
               crc_q <= crc_chunk(crc_q, sh_q[MSG_W-1 -: CHUNK_W]);
               sh_q  <= sh_q << CHUNK_W;
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == CNT_W'(NCH - 1)) begin
                  run_q  <= 1'b0;
                  done_q <= 1'b1;
               end
            end else begin
               done_q <= 1'b0;
            end
         end

         assign done = done_q;
         assign code = crc_q;

         // R10: one sequence at a time, never restarted mid-run
         assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
            start |-> !run_q);
         assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
            done |=> !done);
      end
   endgenerate

endmodule

// File: rtl/secmem_guard.sv
module secmem_guard #(
   parameter int               DATA_W  = 32,
   parameter int               ADDR_W  = 32,
   parameter int               ID_W    = 4,
   parameter int               KEY_W   = 128,
   parameter int               MAC_W   = 128,
   parameter int               CHUNK_W = 16,
   parameter logic [MAC_W-1:0] POLY    = 128'h87
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_store,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [ID_W-1:0]   req_src_tag,
   input  logic [ID_W-1:0]   cur_id,
   output logic [ID_W-1:0]   key_id,
   input  logic [KEY_W-1:0]  key_in,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic [ID_W-1:0]   rsp_tag,
   output logic              rsp_tag_valid,
   output logic              rsp_viol,
   output logic              rsp_mac_err,
   output logic              busy,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_write,
   output logic [ADDR_W-1:0] mem_req_addr,
   output logic [DATA_W-1:0] mem_req_wdata,
   output logic [MAC_W-1:0]  mem_req_wmac,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_rdata,
   input  logic [MAC_W-1:0]  mem_rsp_rmac
);

   import secmem_pkg::*;

   localparam int MSG_W = KEY_W + ADDR_W + DATA_W;

   generate
      if (ID_W < 1 || ADDR_W < 1) begin : g_bad_w
         $error("secmem_guard: ID_W and ADDR_W must be positive");
      end
      if (MAC_W < 8) begin : g_bad_mac
         $error("secmem_guard: MAC_W below 8 gives no useful integrity");
      end
   endgenerate

   secmem_state_e     st_q;
   logic              store_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] pt_q;
   logic [KEY_W-1:0]  key_q;
   logic [ID_W-1:0]   id_q;
   logic [MAC_W-1:0]  mac_q;
   logic [DATA_W-1:0] rdata_q;
   logic              tv_q;
   logic              viol_q;
   logic              merr_q;

   logic              accept;
   logic              tag_ok;
   logic              start_st;
   logic              start_ld;
   logic              crc_start;
   logic [MSG_W-1:0]  crc_msg;
   logic              crc_done;
   logic [MAC_W-1:0]  crc_code;
   logic [DATA_W-1:0] enc_out;
   logic [DATA_W-1:0] dec_out;

   assign key_id   = cur_id;
   assign accept   = req_valid && (st_q == SM_IDLE);
   assign tag_ok   = (req_src_tag == cur_id);
   assign start_st = accept && req_store && tag_ok;
   assign start_ld = (st_q == SM_MEMWAIT) && mem_rsp_valid;
   assign crc_start = start_st || start_ld;
   assign crc_msg  = start_st ? {key_in, req_addr, req_wdata}
                              : {key_q, addr_q, dec_out};

   secmem_xor_cipher #(.DATA_W(DATA_W), .KEY_W(KEY_W)) u_enc (
      .din  (pt_q),
      .key  (key_q),
      .dout (enc_out)
   );

   secmem_xor_cipher #(.DATA_W(DATA_W), .KEY_W(KEY_W)) u_dec (
      .din  (mem_rsp_rdata),
      .key  (key_q),
      .dout (dec_out)
   );

   secmem_crc_seq #(
      .MAC_W   (MAC_W),
      .MSG_W   (MSG_W),
      .CHUNK_W (CHUNK_W),
      .POLY    (POLY)
   ) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .start (crc_start),
      .msg   (crc_msg),
      .done  (crc_done),
      .code  (crc_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= SM_IDLE;
         store_q <= 1'b0;
         addr_q  <= '0;
         pt_q    <= '0;
         key_q   <= '0;
         id_q    <= '0;
         mac_q   <= '0;
         rdata_q <= '0;
         tv_q    <= 1'b0;
         viol_q  <= 1'b0;
         merr_q  <= 1'b0;
      end else begin
         unique case (st_q)
            SM_IDLE: begin
               if (accept) begin
                  store_q <= req_store;
                  addr_q  <= req_addr;
                  pt_q    <= req_wdata;
                  key_q   <= key_in;
                  id_q    <= cur_id;
                  rdata_q <= '0;
                  tv_q    <= 1'b0;
                  viol_q  <= 1'b0;
                  merr_q  <= 1'b0;
                  if (req_store && !tag_ok) begin
                     viol_q <= 1'b1;
                     st_q   <= SM_RESP;
                  end else if (req_store) begin
                     st_q <= SM_HASH;
                  end else begin
                     st_q <= SM_MEMREQ;
                  end
               end
            end
            SM_HASH: begin
               if (crc_done) begin
                  if (store_q) begin
                     mac_q <= crc_code;
                     st_q  <= SM_MEMREQ;
                  end else begin
                     if (crc_code == mac_q) begin
                        rdata_q <= pt_q;
                        tv_q    <= 1'b1;
                     end else begin
                        merr_q  <= 1'b1;
                     end
                     st_q <= SM_RESP;
                  end
               end
            end
            SM_MEMREQ: begin
               if (mem_req_ready) begin
                  st_q <= store_q ? SM_RESP : SM_MEMWAIT;
               end
            end
            SM_MEMWAIT: begin
               if (mem_rsp_valid) begin
                  pt_q  <= dec_out;
                  mac_q <= mem_rsp_rmac;
                  st_q  <= SM_HASH;
               end
            end
            SM_RESP: begin
               st_q <= SM_IDLE;
            end
            default: st_q <= SM_IDLE;
         endcase
      end
   end

   assign req_ready     = (st_q == SM_IDLE);
   assign busy          = (st_q != SM_IDLE);
   assign rsp_valid     = (st_q == SM_RESP);
   assign rsp_data      = rdata_q;
   assign rsp_tag       = tv_q ? id_q : '0;
   assign rsp_tag_valid = tv_q;
   assign rsp_viol      = viol_q;
   assign rsp_mac_err   = merr_q;

   assign mem_req_valid = (st_q == SM_MEMREQ);
   assign mem_req_write = store_q;
   assign mem_req_addr  = addr_q;
   assign mem_req_wdata = enc_out;
   assign mem_req_wmac  = mac_q;

   // R1: an accepted request makes the unit busy on the next cycle
   assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> busy);

   // R2: ownership mismatch answers at once and never reaches memory
   assert_viol_no_mem_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_store && (req_src_tag != cur_id))
      |=> (rsp_valid && rsp_viol && !mem_req_valid));

   // R5: a stalled beat keeps ciphertext and code together and unchanged
   assert_beat_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready)
      |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wdata)
           && $stable(mem_req_wmac) && $stable(mem_req_write)));

   // R7: a failed check carries neither data nor a tag
   assert_fail_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_mac_err) |-> (rsp_data == '0 && !rsp_tag_valid && rsp_tag == '0));

   // R10: the response strobe lasts one cycle
   assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

endmodule

// File: tb/tb_secmem_guard.sv
`timescale 1ns/1ps
module tb_secmem_guard;

   localparam int               DW   = 32;
   localparam int               AW   = 32;
   localparam int               IW   = 4;
   localparam int               KW   = 128;
   localparam int               MW   = 128;
   localparam logic [MW-1:0]    POLY = 128'h87;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_store = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [IW-1:0] req_src_tag = '0;
   logic [IW-1:0] cur_id = '0;
   logic [IW-1:0] key_id;
   logic [KW-1:0] key_in;
   logic          rsp_valid;
   logic [DW-1:0] rsp_data;
   logic [IW-1:0] rsp_tag;
   logic          rsp_tag_valid, rsp_viol, rsp_mac_err, busy;
   logic          mem_req_valid;
   logic          mem_req_ready = 1'b0;
   logic          mem_req_write;
   logic [AW-1:0] mem_req_addr;
   logic [DW-1:0] mem_req_wdata;
   logic [MW-1:0] mem_req_wmac;
   logic          mem_rsp_valid = 1'b0;
   logic [DW-1:0] mem_rsp_rdata = '0;
   logic [MW-1:0] mem_rsp_rmac = '0;

   always #5 clk = ~clk;

   secmem_guard dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_src_tag(req_src_tag),
      .cur_id(cur_id), .key_id(key_id), .key_in(key_in),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_tag(rsp_tag),
      .rsp_tag_valid(rsp_tag_valid), .rsp_viol(rsp_viol), .rsp_mac_err(rsp_mac_err),
      .busy(busy),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
      .mem_req_wdata(mem_req_wdata), .mem_req_wmac(mem_req_wmac),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
      .mem_rsp_rmac(mem_rsp_rmac)
   );

   // key table and behavioural memory
   logic [KW-1:0] key_tab [16];
   logic [DW-1:0] m_ct  [logic [AW-1:0]];
   logic [MW-1:0] m_mac [logic [AW-1:0]];
   logic [DW-1:0] sh_data [logic [AW-1:0]];
   logic [IW-1:0] sh_id   [logic [AW-1:0]];
   assign key_in = key_tab[key_id];

   int  n_vec = 0;
   int  n_fail = 0;
   int  wr_count = 0;
   bit  pending = 1'b0;
   bit  live = 1'b0;
   bit  ended = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [MW-1:0] act,
                      input logic [MW-1:0] exp);
      n_vec++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   endtask

   function automatic logic [DW-1:0] kfold(input logic [KW-1:0] k);
      return k[31:0] ^ k[63:32] ^ k[95:64] ^ k[127:96];
   endfunction

   function automatic logic [MW-1:0] crc_ref(input logic [KW-1:0] k,
                                             input logic [AW-1:0] a,
                                             input logic [DW-1:0] d);
      logic [KW+AW+DW-1:0] m;
      logic [MW-1:0]       c;
      logic                fb;
      m = {k, a, d};
      c = '0;
      for (int i = KW + AW + DW - 1; i >= 0; i--) begin
         fb = c[MW-1] ^ m[i];
         c  = c << 1;
         if (fb) c = c ^ POLY;
      end
      return c;
   endfunction

   // memory responder: random stalls, random read latency
   initial begin
      bit            rd_act = 1'b0;
      int            rd_cnt = 0;
      logic [DW-1:0] rd_d = '0;
      logic [MW-1:0] rd_m = '0;
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (rd_act) begin
            if (rd_cnt == 0) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_rdata = rd_d;
               mem_rsp_rmac  = rd_m;
               rd_act = 1'b0;
            end else begin
               rd_cnt--;
            end
         end
         mem_req_ready = ($urandom % 3) != 0;
         if (mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
               m_ct[mem_req_addr]  = mem_req_wdata;
               m_mac[mem_req_addr] = mem_req_wmac;
               wr_count++;
            end else begin
               rd_act = 1'b1;
               rd_cnt = $urandom % 3;
               rd_d = m_ct.exists(mem_req_addr)  ? m_ct[mem_req_addr]  : '0;
               rd_m = m_mac.exists(mem_req_addr) ? m_mac[mem_req_addr] : '0;
            end
         end
      end
   end

   // per-cycle reference: busy and ready follow the outstanding-request model (R1, R10)
   initial begin
      forever begin
         @(negedge clk);
         if (live) begin
            chk(busy == pending, "R1 busy vs model", MW'(busy), MW'(pending));
            chk(req_ready == !pending, "R10 ready vs model", MW'(req_ready), MW'(!pending));
         end
      end
   end

   task automatic issue(input bit st, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [IW-1:0] src, input logic [IW-1:0] cur);
      int guard = 0;
      @(negedge clk);
      req_valid = 1'b1; req_store = st; req_addr = a; req_wdata = d;
      req_src_tag = src; cur_id = cur;
      while (!req_ready && guard < 500) begin @(negedge clk); guard++; end
      chk(key_id == cur, "R3 key_id", MW'(key_id), MW'(cur));
      @(posedge clk);
      pending = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      guard = 0;
      while (!rsp_valid && guard < 500) begin @(negedge clk); guard++; end
      chk(rsp_valid, "R10 response seen", MW'(rsp_valid), 1);
   endtask

   task automatic close_rsp();
      @(posedge clk);
      pending = 1'b0;
      @(negedge clk);
      chk(!rsp_valid, "R10 single-cycle response", MW'(rsp_valid), 0);
   endtask

   task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic [IW-1:0] src, input logic [IW-1:0] cur);
      int wb = wr_count;
      bit v = (src != cur);
      issue(1'b1, a, d, src, cur);
      chk(rsp_viol == v, "R2 viol flag", MW'(rsp_viol), MW'(v));
      chk(!rsp_mac_err && !rsp_tag_valid, "R2 store rsp flags",
          MW'({rsp_mac_err, rsp_tag_valid}), 0);
      close_rsp();
      if (v) begin
         chk(wr_count == wb, "R2 no write", MW'(wr_count), MW'(wb));
      end else begin
         chk(wr_count == wb + 1, "R5 one beat", MW'(wr_count), MW'(wb + 1));
         chk(m_ct[a] == (d ^ kfold(key_tab[cur])), "R3 ciphertext",
             MW'(m_ct[a]), MW'(d ^ kfold(key_tab[cur])));
         chk(m_mac[a] == crc_ref(key_tab[cur], a, d), "R4 code",
             m_mac[a], crc_ref(key_tab[cur], a, d));
         sh_data[a] = d;
         sh_id[a]   = cur;
      end
   endtask

   task automatic do_load(input logic [AW-1:0] a, input logic [IW-1:0] cur,
                          input bit ok, input logic [DW-1:0] d, input string rq);
      issue(1'b0, a, '0, cur, cur);
      if (ok) begin
         chk(rsp_data == d, {rq, " data"}, MW'(rsp_data), MW'(d));
         chk(rsp_tag_valid && rsp_tag == cur && !rsp_mac_err && !rsp_viol,
             {rq, " tag"}, MW'({rsp_tag_valid, rsp_tag, rsp_mac_err}),
             MW'({1'b1, cur, 1'b0}));
      end else begin
         chk(rsp_mac_err && rsp_data == '0 && !rsp_tag_valid && rsp_tag == '0,
             {rq, " fault"}, MW'({rsp_mac_err, rsp_tag_valid, rsp_data}),
             MW'({1'b1, 1'b0, 32'h0}));
      end
      close_rsp();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_vec++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [DW-1:0] sv_ct;
      logic [MW-1:0] sv_mac;
      for (int i = 0; i < 16; i++) begin
         key_tab[i] = {32'h0123_4567 + 32'(i), 32'h89AB_CDEF ^ (32'(i) * 32'd7),
                       32'hDEAD_0000 | 32'(i), 32'h5A5A_5A5A ^ (32'(i) * 32'h1111_1111)};
      end
      repeat (3) @(negedge clk);
      chk(req_ready && !busy && !rsp_valid && !mem_req_valid, "R1 reset state",
          MW'({req_ready, busy, rsp_valid, mem_req_valid}), MW'(4'b1000));
      rst_n = 1'b1;
      @(negedge clk);
      live = 1'b1;

      do_store(32'h0000_1000, 32'hCAFE_F00D, 4'd3, 4'd3);
      do_load (32'h0000_1000, 4'd3, 1'b1, 32'hCAFE_F00D, "R6 round trip");

      do_store(32'h0000_1000, 32'h1111_2222, 4'd2, 4'd3);
      do_load (32'h0000_1000, 4'd3, 1'b1, 32'hCAFE_F00D, "R2 old word kept");

      sv_ct = m_ct[32'h1000]; sv_mac = m_mac[32'h1000];
      m_ct[32'h1000] = sv_ct ^ 32'h0000_0100;
      do_load(32'h0000_1000, 4'd3, 1'b0, '0, "R7 spoofed data");
      m_ct[32'h1000] = sv_ct;
      m_mac[32'h1000] = sv_mac ^ (128'h1 << 100);
      do_load(32'h0000_1000, 4'd3, 1'b0, '0, "R7 spoofed code");
      m_mac[32'h1000] = sv_mac;

      m_ct[32'h2000] = sv_ct; m_mac[32'h2000] = sv_mac;
      do_load(32'h0000_2000, 4'd3, 1'b0, '0, "R8 spliced word");

      do_load(32'h0000_1000, 4'd5, 1'b0, '0, "R9 foreign compartment");
      do_load(32'h0000_1000, 4'd3, 1'b1, 32'hCAFE_F00D, "R6 restored word");

      do_store(32'hFFFF_FFFC, 32'hFFFF_FFFF, 4'd15, 4'd15);
      do_load (32'hFFFF_FFFC, 4'd15, 1'b1, 32'hFFFF_FFFF, "R6 top address");
      do_store(32'h0000_0000, 32'h0000_0000, 4'd0, 4'd0);
      do_load (32'h0000_0000, 4'd0, 1'b1, 32'h0000_0000, "R6 zero word");

      for (int n = 0; n < 16; n++) begin
         logic [AW-1:0] a = 32'h0000_0100 + 32'((n % 4) * 4);
         logic [IW-1:0] id = IW'($urandom % 16);
         do_store(a, $urandom, id, id);
      end
      for (int n = 0; n < 12; n++) begin
         logic [AW-1:0] a = 32'h0000_0100 + 32'((n % 4) * 4);
         if (n % 3 == 2) begin
            logic [IW-1:0] other = sh_id[a] ^ 4'd1;
            do_load(a, other, 1'b0, '0, "R9 random foreign load");
         end else begin
            do_load(a, sh_id[a], 1'b1, sh_data[a], "R6 random load");
         end
      end

      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule